// File: doc/BRIEF.md
# Data and Stack Segment Register Load Checker

This block decides whether a 16-bit selector may be written into the stack segment register or into one of the four data segment registers. Each request carries the operating mode (legacy protected or 64-bit), the target class (stack or data), the selector, the current privilege level and the limit of the descriptor table. Null selectors and selectors whose descriptor would lie past the table limit are resolved at once. Every other selector causes a descriptor fetch through a request/acknowledge port, and the returned access byte is then checked against the privilege and type rules for the target.

Each accepted request ends in exactly one result. That result is either a commit pulse carrying the selector and access byte, or a fault pulse carrying an exception vector and error code. The null stack-selector rule depends on the mode. Protected mode always rejects it. 64-bit mode rejects it only at privilege 3, or when the requested privilege differs from the current one.

Top module: `seg_load_checker`

## Requirements
- R1: After reset, busy_o, fetch_req_o, commit_o and fault_o are all low.
- R2: The selector holds index in bits 15:3, table indicator in bit 2 and requested privilege (RPL) in bits 1:0. A selector is null when bits 15:2 are zero. A null load of a data register commits, with access byte 0, in the cycle after the request edge, and no fetch is issued.
- R3: A non-null selector with {index,3'b111} greater than the table limit faults with vector 13, and the error code is the selector with bits 1:0 cleared. The fault appears in the cycle after the request edge, and no fetch is issued.
- R4: Any other non-null selector raises busy_o and fetch_req_o, with fetch_idx_o/fetch_ti_o taken from the selector, until the edge at which fetch_ack_i is high. The result appears in the next cycle and busy_o drops.
- R5: A request presented while busy_o is high is ignored: the fetch index stays the same and only the original request produces a result.
- R6: In protected mode, a null stack selector faults with vector 13 and error code 0, whatever the privilege levels are.
- R7: In 64-bit mode, a null stack selector faults with vector 13 and code 0 when CPL is 3 or RPL differs from CPL. Otherwise it commits with access byte 0 and no fetch is issued.
- R8: A fetched stack descriptor faults with vector 13 (code = selector with bits 1:0 cleared) in any of these cases: RPL is not CPL, DPL (access bits 6:5) is not CPL, or the descriptor is not a writable data segment (bit 4 = 1, bit 3 = 0 and bit 1 = 1 are all required).
- R9: A stack descriptor that passes R8 with present bit 7 clear faults with vector 12 and the same code. Otherwise it commits the selector and access byte.
- R10: A fetched data-register descriptor faults with vector 13 in any of these cases: bit 4 is clear; it is code (bit 3 = 1) without read (bit 1 = 0); or it is data or nonconforming code (bit 3 = 0 or bit 2 = 0) while RPL or CPL exceeds DPL.
- R11: A data-register descriptor that passes R10 with bit 7 clear faults with vector 11. Otherwise it commits the selector and access byte.
- R12: commit_o and fault_o are never high together. Each accepted request yields exactly one one-cycle pulse of one of them, and fault vectors are limited to 11, 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Load request, accepted when idle |
| long_mode_i | input | 1 | 1 = 64-bit mode, 0 = protected mode |
| tgt_ss_i | input | 1 | 1 = stack register, 0 = data register |
| sel_i | input | 16 | Selector to load |
| cpl_i | input | 2 | Current privilege level |
| tbl_limit_i | input | LIMIT_W | Descriptor table limit in bytes |
| fetch_req_o | output | 1 | Descriptor fetch pending |
| fetch_idx_o | output | 13 | Descriptor index to fetch |
| fetch_ti_o | output | 1 | Table indicator of fetch |
| fetch_ack_i | input | 1 | Descriptor access byte valid |
| fetch_acc_i | input | 8 | Fetched access byte |
| busy_o | output | 1 | Request in progress |
| commit_o | output | 1 | Load accepted pulse |
| commit_sel_o | output | 16 | Committed selector |
| commit_acc_o | output | 8 | Committed access byte |
| fault_o | output | 1 | Load rejected pulse |
| fault_vec_o | output | 8 | Exception vector |
| fault_code_o | output | 16 | Exception error code |

## Verification
Null and over-limit selectors yield a result exactly one cycle after the request edge. Fetched selectors yield their result one cycle after the acknowledge edge, and the delay between fetch and acknowledge is varied from zero to two cycles. The bench drives all inputs on the falling edge and samples on the next falling edge, so each result is read in the one cycle in which it is valid. One cycle later it confirms that both pulses have returned low. While a fetch is waiting, the bench also presents a second request and checks that the fetch index does not move.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int SEL_W = 16;
  localparam int IDX_W = SEL_W - 3;
  localparam int ACC_W = 8;
  localparam int VEC_W = 8;

  localparam logic [VEC_W-1:0] VEC_GP = 8'd13;
  localparam logic [VEC_W-1:0] VEC_SS = 8'd12;
  localparam logic [VEC_W-1:0] VEC_NP = 8'd11;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} st_e;

  typedef struct packed {
    logic             fault;
    logic [VEC_W-1:0] vec;
    logic [SEL_W-1:0] code;
  } verdict_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_chk_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [1:0]         rpl_o,
  output logic               null_o,
  output logic               over_o
);
  localparam int CMP_W = ((LIMIT_W > SEL_W) ? LIMIT_W : SEL_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;

  assign rpl_o     = sel_i[1:0];
  assign null_o    = (sel_i[SEL_W-1:2] == '0);
  // last byte of the 8-byte descriptor must lie inside the table
  assign last_byte = CMP_W'({sel_i[SEL_W-1:3], 3'b111});
  assign lim_ext   = CMP_W'(limit_i);
  assign over_o    = last_byte > lim_ext;
endmodule

// File: rtl/seg_null_eval.sv
module seg_null_eval
  import seg_chk_pkg::*;
(
  input  logic     long_mode_i,
  input  logic     tgt_ss_i,
  input  logic [1:0] rpl_i,
  input  logic [1:0] cpl_i,
  output verdict_t verdict_o
);
  logic ss_reject;

  always_comb begin
    if (long_mode_i) ss_reject = (cpl_i == 2'd3) || (rpl_i != cpl_i);
    else             ss_reject = 1'b1;
    verdict_o.fault = tgt_ss_i && ss_reject;
    verdict_o.vec   = verdict_o.fault ? VEC_GP : '0;
    verdict_o.code  = '0;
  end
endmodule

// File: rtl/seg_desc_eval.sv
module seg_desc_eval
  import seg_chk_pkg::*;
(
  input  logic             tgt_ss_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       cpl_i,
  input  logic [ACC_W-1:0] acc_i,
  output verdict_t         verdict_o
);
  logic       present, sys_n, is_code, conf, rw;
  logic [1:0] dpl, rpl;
  logic       gp, absent;

  assign present = acc_i[7];
  assign dpl     = acc_i[6:5];
  assign sys_n   = acc_i[4];
  assign is_code = acc_i[3];
  assign conf    = acc_i[2];
  assign rw      = acc_i[1];
  assign rpl     = sel_i[1:0];

  always_comb begin
    if (tgt_ss_i)
      gp = (rpl != cpl_i) || (dpl != cpl_i) || !sys_n || is_code || !rw;
    else
      gp = !sys_n || (is_code && !rw) ||
           ((!is_code || !conf) && ((rpl > dpl) || (cpl_i > dpl)));
    absent = !gp && !present;

    verdict_o.fault = gp || absent;
    verdict_o.code  = verdict_o.fault ? {sel_i[SEL_W-1:2], 2'b00} : '0;
    if (gp)          verdict_o.vec = VEC_GP;
    else if (absent) verdict_o.vec = tgt_ss_i ? VEC_SS : VEC_NP;
    else             verdict_o.vec = '0;
  end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_chk_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               long_mode_i,
  input  logic               tgt_ss_i,
  input  logic [15:0]        sel_i,
  input  logic [1:0]         cpl_i,
  input  logic [LIMIT_W-1:0] tbl_limit_i,
  output logic               fetch_req_o,
  output logic [12:0]        fetch_idx_o,
  output logic               fetch_ti_o,
  input  logic               fetch_ack_i,
  input  logic [7:0]         fetch_acc_i,
  output logic               busy_o,
  output logic               commit_o,
  output logic [15:0]        commit_sel_o,
  output logic [7:0]         commit_acc_o,
  output logic               fault_o,
  output logic [7:0]         fault_vec_o,
  output logic [15:0]        fault_code_o
);
  st_e              state_q;
  logic [SEL_W-1:0] sel_q;
  logic             tgt_q;
  logic [1:0]       cpl_q;

  logic             commit_q, fault_q;
  logic [SEL_W-1:0] csel_q, code_q;
  logic [ACC_W-1:0] cacc_q;
  logic [VEC_W-1:0] vec_q;

  logic [1:0] rpl_in;
  logic       null_in, over_in;
  verdict_t   null_v, desc_v, res_v;
  logic       res_fire;
  logic [SEL_W-1:0] res_sel;
  logic [ACC_W-1:0] res_acc;
  logic       go_wait;

  seg_sel_decode #(.LIMIT_W(LIMIT_W)) i_decode (
    .sel_i   (sel_i),
    .limit_i (tbl_limit_i),
    .rpl_o   (rpl_in),
    .null_o  (null_in),
    .over_o  (over_in)
  );

  seg_null_eval i_null (
    .long_mode_i (long_mode_i),
    .tgt_ss_i    (tgt_ss_i),
    .rpl_i       (rpl_in),
    .cpl_i       (cpl_i),
    .verdict_o   (null_v)
  );

  seg_desc_eval i_desc (
    .tgt_ss_i  (tgt_q),
    .sel_i     (sel_q),
    .cpl_i     (cpl_q),
    .acc_i     (fetch_acc_i),
    .verdict_o (desc_v)
  );

  always_comb begin
    res_fire = 1'b0;
    res_v    = '0;
    res_sel  = sel_i;
    res_acc  = '0;
    go_wait  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (null_in) begin
            res_fire = 1'b1;
            res_v    = null_v;
          end else if (over_in) begin
            res_fire    = 1'b1;
            res_v.fault = 1'b1;
            res_v.vec   = VEC_GP;
            res_v.code  = {sel_i[SEL_W-1:2], 2'b00};
          end else begin
            go_wait = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (fetch_ack_i) begin
          res_fire = 1'b1;
          res_v    = desc_v;
          res_sel  = sel_q;
          res_acc  = fetch_acc_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      tgt_q    <= 1'b0;
      cpl_q    <= '0;
      commit_q <= 1'b0;
      fault_q  <= 1'b0;
      csel_q   <= '0;
      cacc_q   <= '0;
      vec_q    <= '0;
      code_q   <= '0;
    end else begin
      commit_q <= 1'b0;
      fault_q  <= 1'b0;
      if (go_wait) begin
        state_q <= ST_WAIT;
        sel_q   <= sel_i;
        tgt_q   <= tgt_ss_i;
        cpl_q   <= cpl_i;
      end else if (res_fire) begin
        state_q <= ST_IDLE;
      end
      if (res_fire) begin
        if (res_v.fault) begin
          fault_q <= 1'b1;
          vec_q   <= res_v.vec;
          code_q  <= res_v.code;
        end else begin
          commit_q <= 1'b1;
          csel_q   <= res_sel;
          cacc_q   <= res_acc;
        end
      end
    end
  end

  assign busy_o       = (state_q == ST_WAIT);
  assign fetch_req_o  = busy_o;
  assign fetch_idx_o  = sel_q[SEL_W-1:3];
  assign fetch_ti_o   = sel_q[2];
  assign commit_o     = commit_q;
  assign commit_sel_o = csel_q;
  assign commit_acc_o = cacc_q;
  assign fault_o      = fault_q;
  assign fault_vec_o  = vec_q;
  assign fault_code_o = code_q;
endmodule

// File: rtl/seg_load_sva.sv
module seg_load_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        long_mode_i,
  input logic        tgt_ss_i,
  input logic [15:0] sel_i,
  input logic [1:0]  cpl_i,
  input logic        fetch_ack_i,
  input logic        fetch_req_o,
  input logic [12:0] fetch_idx_o,
  input logic        fetch_ti_o,
  input logic        busy_o,
  input logic        commit_o,
  input logic        fault_o,
  input logic [7:0]  fault_vec_o,
  input logic [15:0] fault_code_o
);
  logic idle_null_req;
  assign idle_null_req = !busy_o && req_i && (sel_i[15:2] == 14'd0);

  // R12
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && fault_o));

  // R12
  vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_vec_o == 8'd11 || fault_vec_o == 8'd12 || fault_vec_o == 8'd13));

  // R4
  ack_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ack_i) |=> ((commit_o || fault_o) && !busy_o));

  // R5
  hold_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fetch_ack_i) |=> (busy_o && $stable(fetch_idx_o) && $stable(fetch_ti_o)));

  // R2
  null_nofetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_null_req |=> (!fetch_req_o && (commit_o || fault_o)));

  // R6
  pm_null_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_null_req && !long_mode_i && tgt_ss_i) |=> (fault_o && fault_code_o == 16'd0));

  // R7
  lm_null_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_null_req && long_mode_i && tgt_ss_i && cpl_i != 2'd3 && sel_i[1:0] == cpl_i)
      |=> commit_o);
endmodule

bind seg_load_checker seg_load_sva i_seg_load_sva (.*);

// File: tb/test_seg_load_checker.sv
module test_seg_load_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        long_mode_i = 1'b0;
  logic        tgt_ss_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [1:0]  cpl_i = '0;
  logic [15:0] tbl_limit_i = '0;
  logic        fetch_req_o;
  logic [12:0] fetch_idx_o;
  logic        fetch_ti_o;
  logic        fetch_ack_i = 1'b0;
  logic [7:0]  fetch_acc_i = '0;
  logic        busy_o;
  logic        commit_o;
  logic [15:0] commit_sel_o;
  logic [7:0]  commit_acc_o;
  logic        fault_o;
  logic [7:0]  fault_vec_o;
  logic [15:0] fault_code_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  seg_load_checker i_seg_load_checker (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit lm, input bit ss, input logic [15:0] sel,
      input logic [1:0] cpl, input logic [7:0] acc, input logic [15:0] lim,
      output bit f, output logic [7:0] v, output logic [15:0] c,
      output logic [7:0] ca, output string tag);
    logic [1:0] rpl, dpl;
    logic [15:0] ec;
    bit bad;
    rpl = sel[1:0]; dpl = acc[6:5]; ec = {sel[15:2], 2'b00};
    f = 1'b0; v = '0; c = '0; ca = acc;
    if (sel[15:2] == 14'd0) begin
      ca = '0;
      tag = "R2";
      if (ss) begin
        tag = lm ? "R7" : "R6";
        if (!lm || cpl == 2'd3 || rpl != cpl) begin f = 1'b1; v = 8'd13; end
      end
    end else if (int'({sel[15:3], 3'b111}) > int'(lim)) begin
      tag = "R3"; f = 1'b1; v = 8'd13; c = ec;
    end else if (ss) begin
      bad = (rpl != cpl) || (dpl != cpl) || !acc[4] || acc[3] || !acc[1];
      if (bad) begin tag = "R8"; f = 1'b1; v = 8'd13; c = ec; end
      else begin
        tag = "R9";
        if (!acc[7]) begin f = 1'b1; v = 8'd12; c = ec; end
      end
    end else begin
      bad = !acc[4] || (acc[3] && !acc[1]) ||
            ((!acc[3] || !acc[2]) && ((rpl > dpl) || (cpl > dpl)));
      if (bad) begin tag = "R10"; f = 1'b1; v = 8'd13; c = ec; end
      else begin
        tag = "R11";
        if (!acc[7]) begin f = 1'b1; v = 8'd11; c = ec; end
      end
    end
  endfunction

  task automatic run_req(input bit lm, input bit ss, input logic [15:0] sel,
      input logic [1:0] cpl, input logic [7:0] acc, input logic [15:0] lim,
      input int lat, input bit disturb);
    bit f; logic [7:0] v; logic [15:0] c; logic [7:0] ca; string tag;
    bit direct;
    logic [63:0] act, exp;
    model(lm, ss, sel, cpl, acc, lim, f, v, c, ca, tag);
    direct = (sel[15:2] == 14'd0) || (int'({sel[15:3], 3'b111}) > int'(lim));
    @(negedge clk_i);
    long_mode_i = lm; tgt_ss_i = ss; sel_i = sel; cpl_i = cpl; tbl_limit_i = lim;
    req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    if (!direct) begin
      // R4 fetch issued with selector fields
      check(busy_o && fetch_req_o && fetch_idx_o == sel[15:3] && fetch_ti_o == sel[2] && !commit_o && !fault_o,
            "R4", {48'd0, busy_o, fetch_req_o, fetch_ti_o, fetch_idx_o}, {48'd0, 3'b111, sel[15:3]});
      for (int k = 0; k < lat; k++) begin
        if (disturb) begin
          req_i = 1'b1; sel_i = ~sel; tgt_ss_i = ~ss;
        end
        @(posedge clk_i);
        @(negedge clk_i);
        req_i = 1'b0;
        // R5 second request ignored
        check(busy_o && fetch_idx_o == sel[15:3] && !commit_o && !fault_o, "R5",
              {51'd0, fetch_idx_o}, {51'd0, sel[15:3]});
      end
      fetch_ack_i = 1'b1; fetch_acc_i = acc;
      @(posedge clk_i);
      @(negedge clk_i);
      fetch_ack_i = 1'b0;
    end else begin
      // R2 R3: no fetch for null or out-of-limit
      check(!fetch_req_o && !busy_o, direct && sel[15:2] == 0 ? "R2" : "R3",
            {62'd0, fetch_req_o, busy_o}, 64'd0);
    end
    exp = f ? {6'd0, 1'b0, 1'b1, v, c, 16'd0, 8'd0} : {6'd0, 1'b1, 1'b0, 8'd0, 16'd0, sel, ca};
    act = fault_o ? {6'd0, commit_o, 1'b1, fault_vec_o, fault_code_o, 16'd0, 8'd0}
                  : {6'd0, commit_o, 1'b0, 8'd0, 16'd0, commit_sel_o, commit_acc_o};
    check(act == exp && !busy_o, tag, act, exp);
    @(posedge clk_i);
    @(negedge clk_i);
    // R12 single pulse
    check(!commit_o && !fault_o, "R12", {62'd0, commit_o, fault_o}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!busy_o && !fetch_req_o && !commit_o && !fault_o, "R1",
          {60'd0, busy_o, fetch_req_o, commit_o, fault_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !fetch_req_o && !commit_o && !fault_o, "R1",
          {60'd0, busy_o, fetch_req_o, commit_o, fault_o}, 64'd0);

    // null selectors: R2 R6 R7
    for (int lm = 0; lm < 2; lm++)
      for (int ss = 0; ss < 2; ss++)
        for (int cpl = 0; cpl < 4; cpl++)
          for (int rpl = 0; rpl < 4; rpl++)
            run_req(lm[0], ss[0], {14'd0, rpl[1:0]}, cpl[1:0], 8'h00, 16'h003F, 0, 1'b0);

    // table limit boundaries: R3 R4
    for (int li = 0; li < 8; li++) begin
      logic [15:0] lims [8];
      lims = '{16'd0, 16'd7, 16'd8, 16'd15, 16'd16, 16'd63, 16'd64, 16'd127};
      for (int idx = 0; idx < 20; idx++)
        run_req(1'b0, 1'b0, {idx[12:0], (idx == 0) ? 1'b1 : idx[0], 2'b00}, 2'd0,
                8'hF3, lims[li], 0, 1'b0);
    end

    // descriptor sweep: R8 R9 R10 R11 R5
    for (int acc = 0; acc < 256; acc++)
      for (int ss = 0; ss < 2; ss++)
        for (int cpl = 0; cpl < 4; cpl++)
          for (int rpl = 0; rpl < 4; rpl++)
            run_req(acc[1] ^ rpl[0], ss[0], {13'd3, acc[2], rpl[1:0]}, cpl[1:0],
                    acc[7:0], 16'h003F, (acc + rpl) % 3, acc[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule